// File: doc/BRIEF.md
# Instruction Queue Aligner for a Four-Wide Decoder

This block sits between the instruction fetch path and a four-wide decoder. Each cycle it can take one fetch chunk of 24 bytes. The chunk comes with a halfword start offset, the address of its byte 0 and a mode bit. The mode bit selects fixed 32-bit code or mixed 16/32-bit Thumb code. The block stores the usable halfwords in a circular queue. Each cycle it carves up to four whole instructions from the queue head and presents them on four lanes, each with its encoding, length flag and address. The decoder takes every presented lane in the cycle it is shown.

Because the queue holds halfwords, a Thumb instruction can start on any halfword. A 32-bit instruction whose first half ends a chunk stays in the queue until the next chunk brings its second half. The stored bytes let the decoder keep working across the short gaps that follow a redirect. A flush from redirect logic empties the queue in one cycle.

A small state machine records the condition of the queue. In `Q_EMPTY` no halfwords are held. In `Q_HOLD` exactly one halfword is held, and it is the first half of a 32-bit instruction. In `Q_FLOW` at least one whole instruction sits at the head. The transitions are named as follows. Fill takes the machine from Q_EMPTY or Q_HOLD to a new state when a chunk is accepted. Drain takes the machine from Q_FLOW to Q_EMPTY or Q_HOLD when the lanes consume the last whole instruction. Flush takes the machine from any state to Q_EMPTY. A state with no event stays where it is.

Top module: `aligner_iq`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 0 while `flush` is high, and also while the queue holds more than DEPTH−12 halfwords, which is less than 24 free bytes. Otherwise it is 1. The queue never holds more than DEPTH halfwords.
- R3: In Thumb mode (`in_thumb`=1), a halfword starts a 32-bit instruction when bits [15:11] equal 11101, 11110 or 11111. Any other halfword is a complete 16-bit instruction.
- R4: In fixed mode (`in_thumb`=0), every instruction is 4 bytes long (`out_wide`=1).
- R5: Up to four instructions are presented per cycle, in program order. Valid lanes are packed from lane 0, so `out_valid` is one of 0000, 0001, 0011, 0111 or 1111. Every presented lane is consumed at the next clock edge.
- R6: A 32-bit Thumb instruction whose second halfword has not arrived is not presented. The queue holds it (state Q_HOLD) until a later chunk supplies the second half. It is then presented joined with that half.
- R7: Halfwords of a chunk below `in_off` are discarded. The first instruction of the chunk has address `in_addr + 2*in_off`.
- R8: While `flush` is high no lane is valid. One cycle after a flush the queue is empty, and nothing held before the flush is ever presented.
- R9: Lane format: bits [15:0] of a lane hold the halfword at the lower address. A 16-bit instruction has bits [31:16] = 0 and `out_wide`=0. Each lane address is the address of its first byte. The address of lane k+1 equals the address of lane k plus 4 when lane k is wide, and plus 2 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue (redirect) |
| in_valid | input | 1 | Fetch chunk offered |
| in_ready | output | 1 | Chunk is accepted this cycle |
| in_data | input | 192 | Chunk bytes; byte i at bits [8i+7:8i] |
| in_off | input | 4 | First usable halfword of the chunk |
| in_addr | input | 32 | Address of chunk byte 0 |
| in_thumb | input | 1 | 1 = mixed 16/32-bit code, 0 = fixed 32-bit code |
| out_valid | output | 4 | Lane valid, packed from lane 0 |
| out_instr | output | 128 | Lane k encoding at bits [32k+31:32k] |
| out_addr | output | 128 | Lane k address at bits [32k+31:32k] |
| out_wide | output | 4 | Lane k is a 4-byte instruction |

## Verification
Two functions can fall in the same cycle. The main case is a flush arriving while a new chunk is offered and the lanes still present instructions from the previous chunk. The bench provokes this by raising `flush` and `in_valid` together right after a chunk is accepted. It judges the result by three things: `in_ready` must be low, no lane may be valid, and only the instructions of the chunk sent after the flush may appear. The second case is the arrival of a chunk while the queue is in Q_HOLD with a stranded first half. The bench judges this by whether the joined instruction comes out with the address of its first half.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

    localparam int unsigned IQ_AW = 32;

    // One queued halfword with the attributes needed to carve it later
    typedef struct packed {
        logic [15:0]      hw;
        logic             thumb;
        logic [IQ_AW-1:0] addr;
    } iq_hw_t;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_HOLD  = 2'd1,
        Q_FLOW  = 2'd2
    } iq_state_e;

    // True when the halfword opens a 4-byte instruction
    function automatic logic iq_pair(input logic [15:0] h, input logic thumb);
        return !thumb || (h[15:13] == 3'b111 && h[12:11] != 2'b00);
    endfunction

endpackage

// File: rtl/aligner_store.sv
module aligner_store
    import aligner_pkg::*;
#(
    parameter int unsigned DEPTH    = 32,
    parameter int unsigned CHUNK_HW = 12,
    parameter int unsigned WIN      = 9,
    localparam int unsigned PW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1),
    localparam int unsigned OW = $clog2(CHUNK_HW),
    localparam int unsigned AW = $clog2(WIN + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    wr_en,
    input  logic [CHUNK_HW*16-1:0]  wr_data,
    input  logic [OW-1:0]           wr_off,
    input  logic [IQ_AW-1:0]        wr_addr,
    input  logic                    wr_thumb,
    input  logic [AW-1:0]           rd_adv,
    output iq_hw_t [WIN-1:0]        win,
    output logic [CW-1:0]           count
);

    iq_hw_t         mem [DEPTH];
    logic [PW-1:0]  head;
    logic [PW-1:0]  tail;
    logic [CW-1:0]  wr_cnt;

    assign wr_cnt = wr_en ? (CW'(CHUNK_HW) - CW'(wr_off)) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (clear) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            head  <= head + PW'(rd_adv);
            tail  <= tail + PW'(wr_cnt);
            count <= count - CW'(rd_adv) + wr_cnt;
        end
    end

    // Usable halfwords are packed behind the tail, skipping those below the offset
    always_ff @(posedge clk) begin
        if (wr_en && !clear) begin
            for (int j = 0; j < int'(CHUNK_HW); j++) begin
                if (j >= int'(wr_off)) begin
                    mem[tail + PW'(j) - PW'(wr_off)] <= '{
                        hw:    wr_data[16*j +: 16],
                        thumb: wr_thumb,
                        addr:  wr_addr + IQ_AW'(2 * j)
                    };
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < int'(WIN); i++) begin
            win[i] = mem[head + PW'(i)];
        end
    end

endmodule

// File: rtl/aligner_carve.sv
module aligner_carve
    import aligner_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned WIN   = 9,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned IW = $clog2(WIN),
    localparam int unsigned CW = $clog2(DEPTH + 1),
    localparam int unsigned AW = $clog2(WIN + 1)
) (
    input  iq_hw_t [WIN-1:0]        win,
    input  logic [CW-1:0]           avail,
    output logic [LANES-1:0]        lane_vld,
    output logic [LANES-1:0]        lane_wide,
    output logic [LANES*32-1:0]     lane_instr,
    output logic [LANES*IQ_AW-1:0]  lane_addr,
    output logic [AW-1:0]           used,
    output logic                    stop_pair
);

    logic [IW-1:0] pos [LANES+1];
    logic          go  [LANES+1];

    assign pos[0] = '0;
    assign go[0]  = 1'b1;

    for (genvar k = 0; k < int'(LANES); k++) begin : g_lane
        iq_hw_t h0;
        iq_hw_t h1;
        logic   wide;
        logic   fits;

        assign h0   = win[pos[k]];
        assign h1   = win[pos[k] + IW'(1)];
        assign wide = iq_pair(h0.hw, h0.thumb);
        // A lane fires only if every lane before it fired and its halfwords are present
        assign fits = go[k] && ((CW'(pos[k]) + (wide ? CW'(2) : CW'(1))) <= avail);

        assign go[k+1]  = fits;
        assign pos[k+1] = fits ? (pos[k] + (wide ? IW'(2) : IW'(1))) : pos[k];

        assign lane_vld[k]                 = fits;
        assign lane_wide[k]                = wide;
        assign lane_instr[32*k +: 32]      = wide ? {h1.hw, h0.hw} : {16'h0000, h0.hw};
        assign lane_addr[IQ_AW*k +: IQ_AW] = h0.addr;
    end

    assign used      = AW'(pos[LANES]);
    assign stop_pair = iq_pair(win[pos[LANES]].hw, win[pos[LANES]].thumb);

endmodule

// File: rtl/aligner_iq.sv
module aligner_iq
    import aligner_pkg::*;
#(
    parameter int unsigned DEPTH   = 32,
    parameter int unsigned CHUNK_B = 24,
    parameter int unsigned LANES   = 4,
    localparam int unsigned CHUNK_HW = CHUNK_B / 2,
    localparam int unsigned OW       = $clog2(CHUNK_HW),
    localparam int unsigned WIN      = 2 * LANES + 1,
    localparam int unsigned CW       = $clog2(DEPTH + 1),
    localparam int unsigned AW       = $clog2(WIN + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [CHUNK_B*8-1:0]    in_data,
    input  logic [OW-1:0]           in_off,
    input  logic [IQ_AW-1:0]        in_addr,
    input  logic                    in_thumb,
    output logic [LANES-1:0]        out_valid,
    output logic [LANES*32-1:0]     out_instr,
    output logic [LANES*IQ_AW-1:0]  out_addr,
    output logic [LANES-1:0]        out_wide
);

    iq_state_e              state;
    iq_state_e              state_n;
    iq_state_e              settle;
    iq_hw_t [WIN-1:0]       win;
    logic [CW-1:0]          count;
    logic [CW-1:0]          left;
    logic [CW-1:0]          total;
    logic [LANES-1:0]       c_vld;
    logic [AW-1:0]          c_used;
    logic [AW-1:0]          adv;
    logic                   c_stop_pair;
    logic                   head_pair;
    logic                   take;

    assign in_ready = !flush && (count <= CW'(DEPTH - CHUNK_HW));
    assign take     = in_valid && in_ready;

    aligner_store #(
        .DEPTH    (DEPTH),
        .CHUNK_HW (CHUNK_HW),
        .WIN      (WIN)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (flush),
        .wr_en    (take),
        .wr_data  (in_data),
        .wr_off   (in_off),
        .wr_addr  (in_addr),
        .wr_thumb (in_thumb),
        .rd_adv   (adv),
        .win      (win),
        .count    (count)
    );

    aligner_carve #(
        .LANES (LANES),
        .WIN   (WIN),
        .DEPTH (DEPTH)
    ) u_carve (
        .win        (win),
        .avail      (count),
        .lane_vld   (c_vld),
        .lane_wide  (out_wide),
        .lane_instr (out_instr),
        .lane_addr  (out_addr),
        .used       (c_used),
        .stop_pair  (c_stop_pair)
    );

    // Output process: lanes are shown, and consumed, only in Q_FLOW
    always_comb begin
        out_valid = '0;
        adv       = '0;
        unique case (state)
            Q_FLOW: begin
                if (!flush) begin
                    out_valid = c_vld;
                    adv       = c_used;
                end
            end
            Q_HOLD, Q_EMPTY: begin
                out_valid = '0;
                adv       = '0;
            end
            default: begin
                out_valid = '0;
                adv       = '0;
            end
        endcase
    end

    // Occupancy after this edge and the width class of the new head halfword
    assign left      = count - CW'(adv);
    assign total     = left + (take ? (CW'(CHUNK_HW) - CW'(in_off)) : '0);
    assign head_pair = (left != '0) ? c_stop_pair
                                    : iq_pair(in_data[CHUNK_B*8-16 +: 16], in_thumb);

    always_comb begin
        if (total == '0)                       settle = Q_EMPTY;
        else if (total == CW'(1) && head_pair) settle = Q_HOLD;
        else                                   settle = Q_FLOW;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            Q_EMPTY: state_n = take ? settle : Q_EMPTY;  // fill
            Q_HOLD:  state_n = take ? settle : Q_HOLD;   // fill (second half)
            Q_FLOW:  state_n = settle;                   // drain / fill
            default: state_n = Q_EMPTY;
        endcase
        if (flush) state_n = Q_EMPTY;                    // flush
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_n;
    end

endmodule

// File: rtl/aligner_iq_chk.sv
module aligner_iq_chk
    import aligner_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    flush,
    input logic [LANES-1:0]        out_valid,
    input logic [LANES-1:0]        out_wide,
    input logic [LANES*IQ_AW-1:0]  out_addr,
    input iq_state_e               state,
    input logic [CW-1:0]           count
);

    // R5
    lane_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (LANES'(out_valid + 1'b1) & out_valid) == '0);

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && out_valid == '0));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R6
    hold_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == Q_HOLD |-> (count == CW'(1) && out_valid == '0));

    for (genvar k = 0; k + 1 < int'(LANES); k++) begin : g_step
        // R9
        addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[k+1] |-> out_addr[IQ_AW*(k+1) +: IQ_AW] ==
                out_addr[IQ_AW*k +: IQ_AW] + (out_wide[k] ? IQ_AW'(4) : IQ_AW'(2)));
    end

endmodule

bind aligner_iq aligner_iq_chk #(
    .LANES (LANES),
    .DEPTH (DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .out_valid (out_valid),
    .out_wide  (out_wide),
    .out_addr  (out_addr),
    .state     (state),
    .count     (count)
);

// File: tb/sim_aligner_iq.sv
`timescale 1ns/1ps
module sim_aligner_iq;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [191:0] in_data = '0;
    logic [3:0]   in_off = '0;
    logic [31:0]  in_addr = '0;
    logic         in_thumb = 1'b0;
    logic [3:0]   out_valid;
    logic [127:0] out_instr;
    logic [127:0] out_addr;
    logic [3:0]   out_wide;

    always #2 clk = ~clk;

    aligner_iq u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_off(in_off),
        .in_addr(in_addr), .in_thumb(in_thumb), .out_valid(out_valid),
        .out_instr(out_instr), .out_addr(out_addr), .out_wide(out_wide)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Model of accepted halfwords and of collected lanes
    logic [15:0] st_hw   [512];
    logic [31:0] st_addr [512];
    logic        st_th   [512];
    int          st_n = 0;
    logic [31:0] g_instr [512];
    logic [31:0] g_addr  [512];
    logic        g_wide  [512];
    int          g_n = 0;
    int          acc = 0;
    int          emit = 0;
    int          ready_bad = 0;
    int          therm_bad = 0;
    bit          saw_low = 0;

    task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Collector: samples between the driving edge and the next rising edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !flush) begin
            if (in_ready !== ((acc - emit) <= 20)) ready_bad++;
            if (!in_ready) saw_low = 1;
            if (((out_valid + 4'd1) & out_valid) != 4'd0) therm_bad++;
            for (int k = 0; k < 4; k++) begin
                if (out_valid[k]) begin
                    g_instr[g_n] = out_instr[32*k +: 32];
                    g_addr[g_n]  = out_addr[32*k +: 32];
                    g_wide[g_n]  = out_wide[k];
                    g_n++;
                    emit += out_wide[k] ? 2 : 1;
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic push(input logic [15:0] h [12], input int off, input logic [31:0] a, input logic th);
        @(negedge clk);
        for (int j = 0; j < 12; j++) in_data[16*j +: 16] = h[j];
        in_off = 4'(off); in_addr = a; in_thumb = th; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        acc += 12 - off;
        for (int j = off; j < 12; j++) begin
            st_hw[st_n] = h[j]; st_addr[st_n] = a + 32'(2*j); st_th[st_n] = th; st_n++;
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        #1;
        flush = 1'b0;
        st_n = 0; g_n = 0; acc = 0; emit = 0;
    endtask

    task automatic drain();
        repeat (8) @(negedge clk);
    endtask

    // Walk the accepted halfwords by the width rules (R3, R4) and compare lanes (R5, R9)
    task automatic verify(input string req);
        int p = 0;
        int e = 0;
        while (p < st_n) begin
            logic w;
            logic [31:0] xi;
            w = !st_th[p] || (st_hw[p][15:13] == 3'b111 && st_hw[p][12:11] != 2'b00);
            if (w && p + 1 >= st_n) break;
            xi = w ? {st_hw[p+1], st_hw[p]} : {16'h0, st_hw[p]};
            if (e < g_n) begin
                check({req, " instr"}, g_instr[e] == xi, g_instr[e], xi);
                check({req, " addr R9"}, g_addr[e] == st_addr[p] && g_wide[e] == w, g_addr[e], st_addr[p]);
            end
            p += w ? 2 : 1;
            e++;
        end
        check({req, " count R5"}, g_n == e, 32'(g_n), 32'(e));
    endtask

    task automatic t_reset();
        check("R1 out_valid", out_valid == 4'd0, 32'(out_valid), 32'd0);
        check("R1 in_ready", in_ready == 1'b1, 32'(in_ready), 32'd1);
    endtask

    task automatic t_fixed();
        logic [15:0] h [12];
        for (int j = 0; j < 12; j++) h[j] = 16'(16'h1000 + 16'(j * 16'h0111));
        push(h, 0, 32'h1000, 1'b0);
        @(negedge clk);
        #1;
        check("R5 four lanes", out_valid == 4'hF, 32'(out_valid), 32'hF);
        check("R4 wide lanes", out_wide == 4'hF, 32'(out_wide), 32'hF);
        drain();
        push(h, 4, 32'h2000, 1'b0);
        drain();
        verify("R4");
        check("R7 fixed offset", g_addr[6] == 32'h2008, g_addr[6], 32'h2008);
        do_flush();
    endtask

    task automatic t_split();
        logic [15:0] h [12];
        for (int j = 0; j < 12; j++) h[j] = 16'(16'h0100 + 16'(j));
        h[5] = 16'hF123; h[6] = 16'h8888;
        h[11] = 16'hF000;
        push(h, 3, 32'h4000, 1'b1);
        drain();
        check("R6 held no lane", out_valid == 4'd0, 32'(out_valid), 32'd0);
        check("R6 held count", g_n == 7, 32'(g_n), 32'd7);
        check("R7 first addr", g_addr[0] == 32'h4006, g_addr[0], 32'h4006);
        for (int j = 0; j < 12; j++) h[j] = 16'(16'h0200 + 16'(j));
        h[0] = 16'hF800;
        push(h, 0, 32'h4018, 1'b1);
        drain();
        check("R6 joined instr", g_instr[7] == 32'hF800F000, g_instr[7], 32'hF800F000);
        check("R6 joined addr", g_addr[7] == 32'h4016, g_addr[7], 32'h4016);
        verify("R6");
        do_flush();
    endtask

    task automatic t_codes();
        logic [15:0] h [12];
        h = '{16'hE000, 16'hE800, 16'h0000, 16'hF000, 16'h1111, 16'hF800,
              16'h2222, 16'h4770, 16'hD000, 16'h1234, 16'hE7FF, 16'h0001};
        push(h, 0, 32'h6000, 1'b1);
        drain();
        check("R3 11100 narrow", g_wide[0] == 1'b0, 32'(g_wide[0]), 32'd0);
        check("R3 11101 wide", g_wide[1] == 1'b1, 32'(g_wide[1]), 32'd1);
        check("R3 11110 wide", g_wide[2] == 1'b1, 32'(g_wide[2]), 32'd1);
        check("R3 11111 wide", g_wide[3] == 1'b1, 32'(g_wide[3]), 32'd1);
        check("R3 narrow upper zero R9", g_instr[4] == 32'h00004770, g_instr[4], 32'h00004770);
        verify("R3");
        do_flush();
    endtask

    task automatic t_stream();
        logic [15:0] h [12];
        saw_low = 0;
        for (int c = 0; c < 10; c++) begin
            for (int j = 0; j < 12; j++) begin
                int n = c * 12 + j;
                h[j] = (n % 7 == 3) ? 16'(16'hF000 | 16'(n)) : 16'(n);
            end
            push(h, 0, 32'(32'h9000 + 24 * c), 1'b1);
        end
        drain();
        check("R2 ready rule", ready_bad == 0, 32'(ready_bad), 32'd0);
        check("R2 ready dropped", saw_low == 1'b1, 32'(saw_low), 32'd1);
        check("R5 lanes packed", therm_bad == 0, 32'(therm_bad), 32'd0);
        verify("R5");
        do_flush();
    endtask

    task automatic t_flush();
        logic [15:0] h [12];
        for (int j = 0; j < 12; j++) h[j] = 16'(16'h0300 + 16'(j));
        push(h, 0, 32'hA000, 1'b1);
        @(negedge clk);
        flush = 1'b1;
        for (int j = 0; j < 12; j++) in_data[16*j +: 16] = 16'h0777;
        in_valid = 1'b1;
        #1;
        check("R8 ready low in flush", in_ready == 1'b0, 32'(in_ready), 32'd0);
        check("R8 no lane in flush", out_valid == 4'd0, 32'(out_valid), 32'd0);
        @(posedge clk);
        #1;
        flush = 1'b0; in_valid = 1'b0;
        st_n = 0; g_n = 0; acc = 0; emit = 0;
        @(negedge clk);
        #1;
        check("R8 empty after flush", out_valid == 4'd0, 32'(out_valid), 32'd0);
        check("R8 ready after flush", in_ready == 1'b1, 32'(in_ready), 32'd1);
        for (int j = 0; j < 12; j++) h[j] = 16'(16'h0500 + 16'(j));
        push(h, 5, 32'hB000, 1'b1);
        drain();
        check("R7 offset after flush", g_addr[0] == 32'hB00A, g_addr[0], 32'hB00A);
        check("R8 only new chunk", g_n == 7, 32'(g_n), 32'd7);
        verify("R8");
        do_flush();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_fixed();
        t_split();
        t_codes();
        t_stream();
        t_flush();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule